// File: doc/BRIEF.md
# Descending Stack Pointer Unit

This block keeps the 16-bit stack pointer of a small processor and steers a byte-wide data memory on its behalf. The stack occupies memory from high addresses downward, and the pointer always names the next free byte. A single-byte push stores at the pointer and then moves it down by one. A single-byte pop moves the pointer up by one and then reads. Return addresses are 16 bits wide. They are stored as two bytes over two consecutive cycles, so the pointer moves by two in total.

Software sees the pointer as two 8-bit I/O registers, one for each half. Both reset to zero, so the pointer has to be loaded before the stack is used. The memory sits outside the block and is read combinationally. A request is accepted in any cycle in which `busy_o` is low. A word operation raises `busy_o` for its second cycle.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset both pointer halves read 0x00 and `busy_o` is low.
- R2: A byte push (op code 0) writes `push_data_i[7:0]` to memory at the current pointer P in the accepting cycle and leaves the pointer at P-1.
- R3: A byte pop (op code 1) reads memory at P+1 in the accepting cycle and leaves the pointer at P+1. One cycle later `pop_valid_o` is high for one cycle, with the byte in `pop_data_o[7:0]` and zero in `pop_data_o[15:8]`.
- R4: A word push (op code 2) writes `push_data_i[7:0]` at P in the accepting cycle and `push_data_i[15:8]` at P-1 in the next cycle. `busy_o` is high during that second cycle, and the pointer ends at P-2.
- R5: A word pop (op code 3) reads the high byte from P+1 in the accepting cycle and the low byte from P+2 in the next cycle. The pointer ends at P+2, and `pop_valid_o` carries the 16-bit value one cycle after the second read.
- R6: While `busy_o` is high, stack requests are ignored: no extra memory access takes place and the pointer does not move. `busy_o` never stays high for two cycles in a row.
- R7: On the I/O port, address 0x3D reads the low pointer byte and 0x3E reads the high pointer byte. Every other address reads 0x00.
- R8: An I/O write to 0x3D or 0x3E replaces that half of the pointer. The write is ignored when a stack request is accepted in the same cycle, and it is also ignored while `busy_o` is high.
- R9: Pointer arithmetic wraps modulo 2^16. A push at 0x0000 leaves 0xFFFF, and a pop at 0xFFFF leaves 0x0000.
- R10: Values come back in last-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Stack request |
| op_i | input | 2 | 0 byte push, 1 byte pop, 2 word push, 3 word pop |
| push_data_i | input | 16 | Data to push (bits 7:0 only for a byte push) |
| busy_o | output | 1 | Second cycle of a word operation |
| pop_data_o | output | 16 | Popped value |
| pop_valid_o | output | 1 | `pop_data_o` is valid |
| io_addr_i | input | 6 | I/O register address |
| io_we_i | input | 1 | I/O write strobe |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data (combinational) |
| mem_addr_o | output | 16 | Data memory address |
| mem_we_o | output | 1 | Data memory write enable |
| mem_re_o | output | 1 | Data memory read strobe |
| mem_wdata_o | output | 8 | Data memory write data |
| mem_rdata_i | input | 8 | Data memory read data (combinational) |

## Verification
On every cycle the assertions check four things: how the pointer moves after an accepted byte push, that the second byte of a word push goes one address below the first, that `busy_o` lasts exactly one cycle, and that a pop result always follows a memory read. Only the bench's scenarios can show what needs a memory model or a chain of operations. That covers the byte values and addresses that land in memory, the reassembly of a word in the right byte order, LIFO order, wrap-around at both ends of the address space, and the requests and I/O writes that are ignored during a busy cycle or a stack access.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [1:0] {
        OP_PUSH_B = 2'd0,
        OP_POP_B  = 2'd1,
        OP_PUSH_W = 2'd2,
        OP_POP_W  = 2'd3
    } stk_op_e;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_PUSH_HI = 2'd1,
        PH_POP_LO  = 2'd2
    } stk_phase_e;

endpackage

// File: rtl/stk_ptr_calc.sv
module stk_ptr_calc #(
    parameter int PTR_W = 16
) (
    input  logic [PTR_W-1:0] sp_i,
    output logic [PTR_W-1:0] sp_inc_o,
    output logic [PTR_W-1:0] sp_dec_o
);
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    // Modulo 2^PTR_W arithmetic (R9)
    assign sp_inc_o = sp_i + ONE;
    assign sp_dec_o = sp_i - ONE;
endmodule

// File: rtl/stk_io_port.sv
module stk_io_port #(
    parameter int                PTR_W  = 16,
    parameter int                BYTE_W = 8,
    parameter int                IO_AW  = 6,
    parameter logic [IO_AW-1:0]  LO_OFS = 6'h3D,
    parameter logic [IO_AW-1:0]  HI_OFS = 6'h3E
) (
    input  logic [IO_AW-1:0]  io_addr_i,
    input  logic              io_we_i,
    input  logic [PTR_W-1:0]  sp_i,
    output logic [BYTE_W-1:0] io_rdata_o,
    output logic              wr_lo_o,
    output logic              wr_hi_o
);
    logic hit_lo;
    logic hit_hi;

    assign hit_lo  = (io_addr_i == LO_OFS);
    assign hit_hi  = (io_addr_i == HI_OFS);
    assign wr_lo_o = io_we_i && hit_lo;
    assign wr_hi_o = io_we_i && hit_hi;

    always_comb begin
        if (hit_lo)      io_rdata_o = sp_i[BYTE_W-1:0];
        else if (hit_hi) io_rdata_o = sp_i[PTR_W-1:BYTE_W];
        else             io_rdata_o = '0;
    end
endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  stk_op_e             op_i,
    input  logic [2*BYTE_W-1:0] push_data_i,
    input  logic                wr_lo_i,
    input  logic                wr_hi_i,
    input  logic [BYTE_W-1:0]   io_wdata_i,
    input  logic [PTR_W-1:0]    sp_inc_i,
    input  logic [PTR_W-1:0]    sp_dec_i,
    input  logic [BYTE_W-1:0]   mem_rdata_i,
    output logic [PTR_W-1:0]    sp_o,
    output logic                busy_o,
    output logic [PTR_W-1:0]    mem_addr_o,
    output logic                mem_we_o,
    output logic                mem_re_o,
    output logic [BYTE_W-1:0]   mem_wdata_o,
    output logic [2*BYTE_W-1:0] pop_data_o,
    output logic                pop_valid_o
);
    localparam int WORD_W = 2 * BYTE_W;

    typedef struct packed {
        stk_phase_e         phase;
        logic [PTR_W-1:0]   sp;
        logic [BYTE_W-1:0]  hold;
        logic [WORD_W-1:0]  pop_data;
        logic               pop_valid;
    } seq_state_t;

    seq_state_t state_q, state_d;
    logic       accept;

    assign accept = req_i && (state_q.phase == PH_IDLE);

    always_comb begin
        state_d           = state_q;
        state_d.pop_valid = 1'b0;
        mem_addr_o        = state_q.sp;
        mem_we_o          = 1'b0;
        mem_re_o          = 1'b0;
        mem_wdata_o       = '0;
        case (state_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    case (op_i)
                        OP_PUSH_B: begin
                            mem_we_o    = 1'b1;
                            mem_wdata_o = push_data_i[BYTE_W-1:0];
                            state_d.sp  = sp_dec_i;
                        end
                        OP_POP_B: begin
                            mem_addr_o        = sp_inc_i;
                            mem_re_o          = 1'b1;
                            state_d.sp        = sp_inc_i;
                            state_d.pop_data  = {{BYTE_W{1'b0}}, mem_rdata_i};
                            state_d.pop_valid = 1'b1;
                        end
                        OP_PUSH_W: begin
                            mem_we_o      = 1'b1;
                            mem_wdata_o   = push_data_i[BYTE_W-1:0];
                            state_d.sp    = sp_dec_i;
                            state_d.hold  = push_data_i[WORD_W-1:BYTE_W];
                            state_d.phase = PH_PUSH_HI;
                        end
                        default: begin
                            mem_addr_o    = sp_inc_i;
                            mem_re_o      = 1'b1;
                            state_d.sp    = sp_inc_i;
                            state_d.hold  = mem_rdata_i;
                            state_d.phase = PH_POP_LO;
                        end
                    endcase
                end else begin
                    if (wr_lo_i) state_d.sp[BYTE_W-1:0]     = io_wdata_i;
                    if (wr_hi_i) state_d.sp[PTR_W-1:BYTE_W] = io_wdata_i;
                end
            end
            PH_PUSH_HI: begin
                mem_we_o      = 1'b1;
                mem_wdata_o   = state_q.hold;
                state_d.sp    = sp_dec_i;
                state_d.phase = PH_IDLE;
            end
            PH_POP_LO: begin
                mem_addr_o        = sp_inc_i;
                mem_re_o          = 1'b1;
                state_d.sp        = sp_inc_i;
                state_d.pop_data  = {state_q.hold, mem_rdata_i};
                state_d.pop_valid = 1'b1;
                state_d.phase     = PH_IDLE;
            end
            default: state_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{phase: PH_IDLE, sp: '0, hold: '0, pop_data: '0, pop_valid: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign sp_o        = state_q.sp;
    assign busy_o      = (state_q.phase != PH_IDLE);
    assign pop_data_o  = state_q.pop_data;
    assign pop_valid_o = state_q.pop_valid;

    // R1: reset clears pointer and busy
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (sp_o == '0 && !busy_o));

    // R2: accepted byte push lowers the pointer by one
    a_r2_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_i == OP_PUSH_B) |=> (sp_o == $past(sp_o) - PTR_W'(1)));

    // R4: second byte of a word push lands one address below the first
    a_r4_word_second_write: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_i == OP_PUSH_W) |=>
            (busy_o && mem_we_o && mem_addr_o == $past(mem_addr_o) - PTR_W'(1)));

    // R6: busy never lasts longer than one cycle
    a_r6_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !busy_o);

    // R3 / R5: every pop result follows a memory read
    a_r3_pop_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid_o |-> $past(mem_re_o));
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
    import stk_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int BYTE_W = 8,
    parameter int IO_AW  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  logic [1:0]          op_i,
    input  logic [2*BYTE_W-1:0] push_data_i,
    output logic                busy_o,
    output logic [2*BYTE_W-1:0] pop_data_o,
    output logic                pop_valid_o,
    input  logic [IO_AW-1:0]    io_addr_i,
    input  logic                io_we_i,
    input  logic [BYTE_W-1:0]   io_wdata_i,
    output logic [BYTE_W-1:0]   io_rdata_o,
    output logic [PTR_W-1:0]    mem_addr_o,
    output logic                mem_we_o,
    output logic                mem_re_o,
    output logic [BYTE_W-1:0]   mem_wdata_o,
    input  logic [BYTE_W-1:0]   mem_rdata_i
);
    logic [PTR_W-1:0] sp;
    logic [PTR_W-1:0] sp_inc;
    logic [PTR_W-1:0] sp_dec;
    logic             wr_lo;
    logic             wr_hi;

    stk_ptr_calc #(.PTR_W(PTR_W)) i_calc (
        .sp_i     (sp),
        .sp_inc_o (sp_inc),
        .sp_dec_o (sp_dec)
    );

    stk_io_port #(
        .PTR_W  (PTR_W),
        .BYTE_W (BYTE_W),
        .IO_AW  (IO_AW),
        .LO_OFS (IO_AW'(6'h3D)),
        .HI_OFS (IO_AW'(6'h3E))
    ) i_io (
        .io_addr_i  (io_addr_i),
        .io_we_i    (io_we_i),
        .sp_i       (sp),
        .io_rdata_o (io_rdata_o),
        .wr_lo_o    (wr_lo),
        .wr_hi_o    (wr_hi)
    );

    stk_seq #(.PTR_W(PTR_W), .BYTE_W(BYTE_W)) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .op_i        (stk_op_e'(op_i)),
        .push_data_i (push_data_i),
        .wr_lo_i     (wr_lo),
        .wr_hi_i     (wr_hi),
        .io_wdata_i  (io_wdata_i),
        .sp_inc_i    (sp_inc),
        .sp_dec_i    (sp_dec),
        .mem_rdata_i (mem_rdata_i),
        .sp_o        (sp),
        .busy_o      (busy_o),
        .mem_addr_o  (mem_addr_o),
        .mem_we_o    (mem_we_o),
        .mem_re_o    (mem_re_o),
        .mem_wdata_o (mem_wdata_o),
        .pop_data_o  (pop_data_o),
        .pop_valid_o (pop_valid_o)
    );
endmodule

// File: tb/test_stack_ptr_unit.sv
`timescale 1ns/1ps
module test_stack_ptr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [1:0]  op_i = 2'd0;
    logic [15:0] push_data_i = '0;
    logic        busy_o;
    logic [15:0] pop_data_o;
    logic        pop_valid_o;
    logic [5:0]  io_addr_i = '0;
    logic        io_we_i = 1'b0;
    logic [7:0]  io_wdata_i = '0;
    logic [7:0]  io_rdata_o;
    logic [15:0] mem_addr_o;
    logic        mem_we_o;
    logic        mem_re_o;
    logic [7:0]  mem_wdata_o;
    logic [7:0]  mem_rdata_i;

    int checks = 0;
    int errors = 0;

    logic [7:0]  mem [256];
    logic [15:0] last_waddr = '0;
    logic [15:0] prev_waddr = '0;
    int          wcount = 0;

    always #4 clk = ~clk;

    assign mem_rdata_i = mem[mem_addr_o[7:0]];

    always @(posedge clk) begin
        if (mem_we_o) begin
            mem[mem_addr_o[7:0]] <= mem_wdata_o;
            prev_waddr <= last_waddr;
            last_waddr <= mem_addr_o;
            wcount     <= wcount + 1;
        end
    end

    stack_ptr_unit i_stack_ptr_unit (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .op_i(op_i),
        .push_data_i(push_data_i), .busy_o(busy_o), .pop_data_o(pop_data_o),
        .pop_valid_o(pop_valid_o), .io_addr_i(io_addr_i), .io_we_i(io_we_i),
        .io_wdata_i(io_wdata_i), .io_rdata_o(io_rdata_o), .mem_addr_o(mem_addr_o),
        .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_sp(output logic [15:0] v);
        io_addr_i = 6'h3D; #1; v[7:0]  = io_rdata_o;
        io_addr_i = 6'h3E; #1; v[15:8] = io_rdata_o;
        io_addr_i = 6'h00;
    endtask

    task automatic wr_sp(input logic [15:0] v);
        @(negedge clk); io_we_i = 1'b1; io_addr_i = 6'h3D; io_wdata_i = v[7:0];
        @(negedge clk); io_addr_i = 6'h3E; io_wdata_i = v[15:8];
        @(negedge clk); io_we_i = 1'b0; io_addr_i = 6'h00;
    endtask

    // Issues one request; returns at the negedge after its last active edge.
    // With hold set, a byte push and an I/O write are driven during the busy cycle.
    task automatic do_op(input logic [1:0] o, input logic [15:0] d, input bit hold);
        @(negedge clk); req_i = 1'b1; op_i = o; push_data_i = d;
        @(negedge clk);
        if (o[1]) begin
            chk("R4/R5 busy in second cycle", {31'd0, busy_o}, 32'd1);
            if (hold) begin
                op_i = 2'd0; push_data_i = 16'h00EE;
                io_we_i = 1'b1; io_addr_i = 6'h3D; io_wdata_i = 8'h77;
            end else begin
                req_i = 1'b0;
            end
            @(negedge clk);
            io_we_i = 1'b0; io_addr_i = 6'h00;
        end
        req_i = 1'b0;
    endtask

    logic [15:0] sp_now;
    logic [15:0] bases [4];

    initial begin
        bases[0] = 16'h0123; bases[1] = 16'h0000; bases[2] = 16'h8001; bases[3] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rd_sp(sp_now);
        chk("R1 pointer after reset", {16'd0, sp_now}, 32'd0);
        chk("R1 busy after reset", {31'd0, busy_o}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        for (int b = 0; b < 4; b++) begin
            logic [15:0] p;
            p = bases[b];
            wr_sp(p);
            rd_sp(sp_now);
            chk("R8 I/O pointer write", {16'd0, sp_now}, {16'd0, p});
            for (int v = 0; v < 16; v++) begin
                logic [7:0]  bv;
                logic [15:0] wv;
                bv = 8'(v * 17) ^ p[7:0];
                wv = {~bv, bv + 8'(b)};
                do_op(2'd0, {8'hCC, bv}, 1'b0);
                rd_sp(sp_now);
                chk("R2 push address", {16'd0, last_waddr}, {16'd0, p});
                chk("R2 push data", {24'd0, mem[p[7:0]]}, {24'd0, bv});
                chk("R2/R9 pointer after push", {16'd0, sp_now}, {16'd0, p - 16'd1});
                do_op(2'd1, 16'h0, 1'b0);
                chk("R3 pop valid", {31'd0, pop_valid_o}, 32'd1);
                chk("R3 pop data", {16'd0, pop_data_o}, {24'd0, bv});
                rd_sp(sp_now);
                chk("R3/R9 pointer after pop", {16'd0, sp_now}, {16'd0, p});
                @(negedge clk);
                chk("R3 valid one cycle", {31'd0, pop_valid_o}, 32'd0);
                do_op(2'd2, wv, 1'b0);
                rd_sp(sp_now);
                chk("R4 low byte address", {16'd0, prev_waddr}, {16'd0, p});
                chk("R4 high byte address", {16'd0, last_waddr}, {16'd0, p - 16'd1});
                chk("R4 low byte data", {24'd0, mem[p[7:0]]}, {24'd0, wv[7:0]});
                chk("R4 high byte data", {24'd0, mem[8'(p[7:0] - 8'd1)]}, {24'd0, wv[15:8]});
                chk("R4/R9 pointer after word push", {16'd0, sp_now}, {16'd0, p - 16'd2});
                do_op(2'd3, 16'h0, 1'b0);
                chk("R5 word pop valid", {31'd0, pop_valid_o}, 32'd1);
                chk("R5 word pop data", {16'd0, pop_data_o}, {16'd0, wv});
                rd_sp(sp_now);
                chk("R5/R9 pointer after word pop", {16'd0, sp_now}, {16'd0, p});
            end
        end

        // R10: LIFO order over mixed operations
        wr_sp(16'h0440);
        do_op(2'd0, 16'h0011, 1'b0);
        do_op(2'd2, 16'hA1B2, 1'b0);
        do_op(2'd0, 16'h0033, 1'b0);
        do_op(2'd1, 16'h0, 1'b0);
        chk("R10 last byte first", {16'd0, pop_data_o}, 32'h0033);
        do_op(2'd3, 16'h0, 1'b0);
        chk("R10 word second", {16'd0, pop_data_o}, 32'hA1B2);
        do_op(2'd1, 16'h0, 1'b0);
        chk("R10 first byte last", {16'd0, pop_data_o}, 32'h0011);
        rd_sp(sp_now);
        chk("R10 pointer restored", {16'd0, sp_now}, 32'h0440);

        // R6 / R8: requests and I/O writes during busy are ignored
        begin
            int w0;
            w0 = wcount;
            do_op(2'd2, 16'h5A6B, 1'b1);
            @(negedge clk);
            rd_sp(sp_now);
            chk("R6 writes during busy", wcount - w0, 32'd2);
            chk("R6/R8 pointer after held push", {16'd0, sp_now}, 32'h043E);
            chk("R6 busy cleared", {31'd0, busy_o}, 32'd0);
            do_op(2'd3, 16'h0, 1'b1);
            chk("R6 word pop result", {16'd0, pop_data_o}, 32'h5A6B);
            rd_sp(sp_now);
            chk("R6/R8 pointer after held pop", {16'd0, sp_now}, 32'h0440);
        end

        // R8: I/O write in the same cycle as an accepted request is ignored
        @(negedge clk);
        req_i = 1'b1; op_i = 2'd0; push_data_i = 16'h0099;
        io_we_i = 1'b1; io_addr_i = 6'h3E; io_wdata_i = 8'h12;
        @(negedge clk);
        req_i = 1'b0; io_we_i = 1'b0; io_addr_i = 6'h00;
        rd_sp(sp_now);
        chk("R8 write beside request ignored", {16'd0, sp_now}, 32'h043F);

        // R7: unmapped I/O addresses read zero
        io_addr_i = 6'h00; #1;
        chk("R7 address 0x00 reads zero", {24'd0, io_rdata_o}, 32'd0);
        io_addr_i = 6'h3F; #1;
        chk("R7 address 0x3F reads zero", {24'd0, io_rdata_o}, 32'd0);
        io_addr_i = 6'h3C; #1;
        chk("R7 address 0x3C reads zero", {24'd0, io_rdata_o}, 32'd0);
        io_addr_i = 6'h3E; #1;
        chk("R7 high half read", {24'd0, io_rdata_o}, 32'h04);
        io_addr_i = 6'h00;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule